// File: doc/BRIEF.md
# IPv4 Forwarding Decision and Header Rewrite

This block sits in the output-port lookup stage of a small IPv4 router. It makes a verdict for each frame and produces the rewritten header fields. It takes the parsed Ethernet type, the twenty-byte IPv4 header, a flag marking frames injected by software, the ingress port, and the outcomes of the route and ARP lookups. It checks the header and a programmable table of the router's own addresses. Its output is a one-hot output port vector, the TTL and header checksum to write back, and a 3-bit reason code.

A frame either takes the hardware fast path, goes out unmodified because software sent it, or is declined. On the fast path the TTL drops by one and the checksum is corrected incrementally. A declined frame gets an empty port vector. A build parameter can instead send declined frames to the CPU queue of their ingress port.

The verdict is registered, so results appear one clock after the input strobe. The header is packed with byte 0 in bits 159:152. Byte n of the header sits in bits 159-8n down to 152-8n.

Top module: `ipv4_fwd_gate`

## Requirements
- R1: `out_valid` is high exactly one cycle after each cycle in which `in_valid` was high. The outputs carry the verdict for that input. Reset clears `out_valid` and `out_ports`.
- R2: Bit 2i of the port vector is MAC port i and bit 2i+1 is CPU queue i. A forwarded frame (reason 0, not from software) sets only bit 2*`rt_port`.
- R3: A frame whose Ethernet type is not 0x0800, including ARP (0x0806), gets reason 1.
- R4: A header whose byte 0 is not 0x45 (version 4, header length 5 words) gets reason 2.
- R5: A header whose ones'-complement sum over its ten 16-bit big-endian words is not 0xFFFF gets reason 3.
- R6: The local table holds `NUM_LOCAL` entries. Entries are written through `loc_we`/`loc_idx`/`loc_addr`/`loc_valid`. A valid entry equal to the destination address (bytes 16..19) gives reason 4. `loc_depth` reports `NUM_LOCAL`.
- R7: A TTL (byte 8) of 0 or 1 gives reason 5.
- R8: A route miss (`rt_hit` low) gives reason 6. A missing ARP entry (`arp_hit` low) gives reason 7.
- R9: When several faults are present, the smallest reason code among them is reported.
- R10: A forwarded frame gets TTL minus one. Its checksum equals a full recomputation of the header holding the new TTL.
- R11: A declined frame keeps its TTL and checksum. Its port vector is all zero when `DECLINE_TO_CPU` is 0. When `DECLINE_TO_CPU` is 1, only bit 2*`in_port`+1 is set.
- R12: A frame with `from_cpu` high gets reason 0 and only bit 2*`in_port`. Its TTL and checksum are unchanged, whatever the header holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input fields hold a frame this cycle |
| eth_type | input | 16 | Parsed Ethernet type |
| ip_hdr | input | 160 | IPv4 header, byte 0 in the top bits |
| from_cpu | input | 1 | Frame was injected by software |
| in_port | input | PW | Ingress port index |
| rt_hit | input | 1 | Route lookup found a prefix |
| rt_port | input | PW | Egress port index from the route lookup |
| arp_hit | input | 1 | ARP lookup found a MAC address |
| loc_we | input | 1 | Write strobe for the local table |
| loc_idx | input | LW | Local table entry to write |
| loc_addr | input | 32 | Address to store |
| loc_valid | input | 1 | Valid flag to store with the address |
| loc_depth | output | 8 | Number of local table entries |
| out_valid | output | 1 | Verdict valid |
| out_ports | output | 2*NUM_PORTS | One-hot output vector |
| out_ttl | output | 8 | TTL to write back |
| out_csum | output | 16 | Header checksum to write back |
| out_reason | output | 3 | 0 forwarded or from software, 1..7 decline cause |

## Verification
The hardest case to reach from the ports is a fault that sits behind a higher-priority fault, because the reported code hides the lower one. The bench covers this in three ways. It sweeps single-bit flips over the whole header, so checksum failures mix with version, TTL and local-address faults. It stacks every fault on one frame and clears them one at a time in priority order. It also sweeps every TTL value and every value of byte 0, recomputing a valid checksum for each, so TTL and version faults reach the decision on their own.

// File: rtl/ipfp_pkg.sv
package ipfp_pkg;

  typedef enum logic [2:0] {
    RSN_OK       = 3'd0,
    RSN_NOT_IP4  = 3'd1,
    RSN_BAD_HDR  = 3'd2,
    RSN_BAD_CSUM = 3'd3,
    RSN_LOCAL    = 3'd4,
    RSN_TTL      = 3'd5,
    RSN_NO_ROUTE = 3'd6,
    RSN_NO_ARP   = 3'd7
  } reason_e;

  localparam int HDR_BYTES = 20;
  localparam int HDR_BITS  = 8 * HDR_BYTES;
  localparam int HDR_WORDS = HDR_BYTES / 2;
  localparam logic [15:0] ETYPE_IP4 = 16'h0800;

  // ones'-complement 16-bit add with end-around carry
  function automatic logic [15:0] oc_add(input logic [15:0] a, input logic [15:0] b);
    logic [16:0] s;
    s = {1'b0, a} + {1'b0, b};
    return s[15:0] + {15'd0, s[16]};
  endfunction

  function automatic logic [15:0] hdr_word(input logic [HDR_BITS-1:0] h, input int i);
    return h[HDR_BITS-1-16*i -: 16];
  endfunction

  function automatic logic [15:0] hdr_sum(input logic [HDR_BITS-1:0] h);
    logic [15:0] acc;
    acc = 16'd0;
    for (int i = 0; i < HDR_WORDS; i++) acc = oc_add(acc, hdr_word(h, i));
    return acc;
  endfunction

  // incremental update: HC' = ~(~HC + ~m + m')
  function automatic logic [15:0] csum_patch(input logic [15:0] hc,
                                             input logic [15:0] m_old,
                                             input logic [15:0] m_new);
    return ~oc_add(oc_add(~hc, ~m_old), m_new);
  endfunction

endpackage

// File: rtl/ipfp_hdr_check.sv
module ipfp_hdr_check
  import ipfp_pkg::*;
(
  input  logic [HDR_BITS-1:0] hdr,
  output logic                ver_ok,
  output logic                sum_ok,
  output logic                ttl_live,
  output logic [31:0]         dst_addr,
  output logic [7:0]          ttl
);
  logic [7:0] b0;

  assign b0       = hdr[HDR_BITS-1 -: 8];
  assign ttl      = hdr[HDR_BITS-1-8*8 -: 8];
  assign dst_addr = hdr[HDR_BITS-1-8*16 -: 32];
  assign ver_ok   = (b0[7:4] == 4'd4) && (b0[3:0] == 4'd5);
  assign sum_ok   = (hdr_sum(hdr) == 16'hFFFF);
  assign ttl_live = (ttl > 8'd1);
endmodule

// File: rtl/ipfp_local_filter.sv
module ipfp_local_filter #(
  parameter int NUM_LOCAL = 4,
  localparam int LW = (NUM_LOCAL > 1) ? $clog2(NUM_LOCAL) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [LW-1:0] wr_idx,
  input  logic [31:0]   wr_addr,
  input  logic          wr_valid,
  input  logic [31:0]   probe,
  output logic          hit
);
  logic [NUM_LOCAL-1:0] match;

  for (genvar e = 0; e < NUM_LOCAL; e++) begin : g_ent
    logic [31:0] addr_q;
    logic        vld_q;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        addr_q <= 32'd0;
        vld_q  <= 1'b0;
      end else if (wr_en && (wr_idx == LW'(e))) begin
        addr_q <= wr_addr;
        vld_q  <= wr_valid;
      end
    end
    assign match[e] = vld_q && (addr_q == probe);
  end

  assign hit = |match;
endmodule

// File: rtl/ipfp_ttl_rewrite.sv
module ipfp_ttl_rewrite
  import ipfp_pkg::*;
(
  input  logic [HDR_BITS-1:0] hdr,
  output logic [7:0]          new_ttl,
  output logic [15:0]         new_csum
);
  logic [7:0]  proto;
  logic [15:0] old_cs;

  assign proto    = hdr[HDR_BITS-1-8*9 -: 8];
  assign old_cs   = hdr[HDR_BITS-1-8*10 -: 16];
  assign new_ttl  = hdr[HDR_BITS-1-8*8 -: 8] - 8'd1;
  assign new_csum = csum_patch(old_cs, hdr_word(hdr, 4), {new_ttl, proto});
endmodule

// File: rtl/ipv4_fwd_gate.sv
module ipv4_fwd_gate
  import ipfp_pkg::*;
#(
  parameter int NUM_PORTS      = 4,
  parameter int NUM_LOCAL      = 4,
  parameter bit DECLINE_TO_CPU = 1'b0,
  localparam int PW = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1,
  localparam int LW = (NUM_LOCAL > 1) ? $clog2(NUM_LOCAL) : 1,
  localparam int VW = 2 * NUM_PORTS
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic [15:0]         eth_type,
  input  logic [HDR_BITS-1:0] ip_hdr,
  input  logic                from_cpu,
  input  logic [PW-1:0]       in_port,
  input  logic                rt_hit,
  input  logic [PW-1:0]       rt_port,
  input  logic                arp_hit,
  input  logic                loc_we,
  input  logic [LW-1:0]       loc_idx,
  input  logic [31:0]         loc_addr,
  input  logic                loc_valid,
  output logic [7:0]          loc_depth,
  output logic                out_valid,
  output logic [VW-1:0]       out_ports,
  output logic [7:0]          out_ttl,
  output logic [15:0]         out_csum,
  output logic [2:0]          out_reason
);
  // named internal events, observed by the checker
  logic        ver_ok, sum_ok, ttl_live, is_local;
  logic [31:0] dst_addr;
  logic [7:0]  ttl_in, ttl_dec;
  logic [15:0] csum_in, csum_fix;
  logic        fwd_c;
  reason_e     rsn_c;
  logic [VW-1:0] mac_rt_vec, mac_in_vec, cpu_in_vec, decline_vec, ports_c;

  assign loc_depth = 8'(NUM_LOCAL);
  assign csum_in   = ip_hdr[HDR_BITS-1-8*10 -: 16];

  ipfp_hdr_check u_chk_hdr (
    .hdr      (ip_hdr),
    .ver_ok   (ver_ok),
    .sum_ok   (sum_ok),
    .ttl_live (ttl_live),
    .dst_addr (dst_addr),
    .ttl      (ttl_in)
  );

  ipfp_local_filter #(.NUM_LOCAL(NUM_LOCAL)) u_local (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (loc_we),
    .wr_idx   (loc_idx),
    .wr_addr  (loc_addr),
    .wr_valid (loc_valid),
    .probe    (dst_addr),
    .hit      (is_local)
  );

  ipfp_ttl_rewrite u_rewrite (
    .hdr      (ip_hdr),
    .new_ttl  (ttl_dec),
    .new_csum (csum_fix)
  );

  // port vectors: bit 2i = MAC port i, bit 2i+1 = CPU queue i
  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_vec
    assign mac_rt_vec[2*p]   = (rt_port == PW'(p));
    assign mac_rt_vec[2*p+1] = 1'b0;
    assign mac_in_vec[2*p]   = (in_port == PW'(p));
    assign mac_in_vec[2*p+1] = 1'b0;
    assign cpu_in_vec[2*p]   = 1'b0;
    assign cpu_in_vec[2*p+1] = (in_port == PW'(p));
  end

  if (DECLINE_TO_CPU) begin : g_decl_cpu
    assign decline_vec = cpu_in_vec;
  end else begin : g_decl_drop
    assign decline_vec = '0;
  end

  always_comb begin
    if (from_cpu)                    rsn_c = RSN_OK;
    else if (eth_type != ETYPE_IP4)  rsn_c = RSN_NOT_IP4;
    else if (!ver_ok)                rsn_c = RSN_BAD_HDR;
    else if (!sum_ok)                rsn_c = RSN_BAD_CSUM;
    else if (is_local)               rsn_c = RSN_LOCAL;
    else if (!ttl_live)              rsn_c = RSN_TTL;
    else if (!rt_hit)                rsn_c = RSN_NO_ROUTE;
    else if (!arp_hit)               rsn_c = RSN_NO_ARP;
    else                             rsn_c = RSN_OK;
  end

  assign fwd_c   = !from_cpu && (rsn_c == RSN_OK);
  assign ports_c = from_cpu ? mac_in_vec : (fwd_c ? mac_rt_vec : decline_vec);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_ports  <= '0;
      out_ttl    <= 8'd0;
      out_csum   <= 16'd0;
      out_reason <= 3'd0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_ports  <= ports_c;
        out_ttl    <= fwd_c ? ttl_dec  : ttl_in;
        out_csum   <= fwd_c ? csum_fix : csum_in;
        out_reason <= rsn_c;
      end
    end
  end
endmodule

// File: rtl/ipv4_fwd_gate_chk.sv
module ipv4_fwd_gate_chk #(
  parameter int NUM_PORTS      = 4,
  parameter bit DECLINE_TO_CPU = 1'b0,
  localparam int PW = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1,
  localparam int VW = 2 * NUM_PORTS
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          from_cpu,
  input logic [PW-1:0] in_port,
  input logic [PW-1:0] rt_port,
  input logic          rt_hit,
  input logic          arp_hit,
  input logic          ver_ok,
  input logic          sum_ok,
  input logic          ttl_live,
  input logic [7:0]    ttl_in,
  input logic [15:0]   csum_in,
  input logic          out_valid,
  input logic [VW-1:0] out_ports,
  input logic [7:0]    out_ttl,
  input logic [15:0]   out_csum,
  input logic [2:0]    out_reason
);
  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid); // R1

  AST_PORTS_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $onehot0(out_ports)); // R2

  AST_FWD_PORT: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_reason == 3'd0 && !$past(from_cpu))
      |-> out_ports == (VW'(1) << (2 * $past(rt_port)))); // R2

  AST_FWD_NEEDS_CHECKS: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_reason == 3'd0 && !$past(from_cpu))
      |-> $past(ver_ok && sum_ok && ttl_live && rt_hit && arp_hit)); // R9

  AST_FWD_TTL: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_reason == 3'd0 && !$past(from_cpu))
      |-> out_ttl == $past(ttl_in) - 8'd1); // R10

  AST_DECLINE_UNTOUCHED: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_reason != 3'd0)
      |-> (out_ttl == $past(ttl_in) && out_csum == $past(csum_in))); // R11

  AST_DECLINE_VEC: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_reason != 3'd0)
      |-> out_ports == (DECLINE_TO_CPU ? (VW'(1) << (2 * $past(in_port) + 1)) : VW'(0))); // R11

  AST_CPU_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(from_cpu))
      |-> (out_reason == 3'd0 && out_ttl == $past(ttl_in)
           && out_ports == (VW'(1) << (2 * $past(in_port))))); // R12
endmodule

bind ipv4_fwd_gate ipv4_fwd_gate_chk #(
  .NUM_PORTS      (NUM_PORTS),
  .DECLINE_TO_CPU (DECLINE_TO_CPU)
) u_fwd_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .from_cpu   (from_cpu),
  .in_port    (in_port),
  .rt_port    (rt_port),
  .rt_hit     (rt_hit),
  .arp_hit    (arp_hit),
  .ver_ok     (ver_ok),
  .sum_ok     (sum_ok),
  .ttl_live   (ttl_live),
  .ttl_in     (ttl_in),
  .csum_in    (csum_in),
  .out_valid  (out_valid),
  .out_ports  (out_ports),
  .out_ttl    (out_ttl),
  .out_csum   (out_csum),
  .out_reason (out_reason)
);

// File: tb/ipv4_fwd_gate_test.sv
module ipv4_fwd_gate_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk; // 50 MHz

  logic         in_valid = 1'b0;
  logic [15:0]  eth_type = 16'h0800;
  logic [159:0] ip_hdr = '0;
  logic         from_cpu = 1'b0;
  logic [1:0]   in_port = 2'd0;
  logic         rt_hit = 1'b0;
  logic [1:0]   rt_port = 2'd0;
  logic         arp_hit = 1'b0;
  logic         loc_we = 1'b0;
  logic [1:0]   loc_idx = 2'd0;
  logic [31:0]  loc_addr = '0;
  logic         loc_valid = 1'b0;

  logic [7:0]  d_depth, c_depth;
  logic        d_valid, c_valid;
  logic [7:0]  d_ports, c_ports;
  logic [7:0]  d_ttl, c_ttl;
  logic [15:0] d_csum, c_csum;
  logic [2:0]  d_rsn, c_rsn;

  ipv4_fwd_gate uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .eth_type(eth_type),
    .ip_hdr(ip_hdr), .from_cpu(from_cpu), .in_port(in_port), .rt_hit(rt_hit),
    .rt_port(rt_port), .arp_hit(arp_hit), .loc_we(loc_we), .loc_idx(loc_idx),
    .loc_addr(loc_addr), .loc_valid(loc_valid), .loc_depth(d_depth),
    .out_valid(d_valid), .out_ports(d_ports), .out_ttl(d_ttl),
    .out_csum(d_csum), .out_reason(d_rsn));

  ipv4_fwd_gate #(.DECLINE_TO_CPU(1'b1)) uut_cpu (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .eth_type(eth_type),
    .ip_hdr(ip_hdr), .from_cpu(from_cpu), .in_port(in_port), .rt_hit(rt_hit),
    .rt_port(rt_port), .arp_hit(arp_hit), .loc_we(loc_we), .loc_idx(loc_idx),
    .loc_addr(loc_addr), .loc_valid(loc_valid), .loc_depth(c_depth),
    .out_valid(c_valid), .out_ports(c_ports), .out_ttl(c_ttl),
    .out_csum(c_csum), .out_reason(c_rsn));

  int n_vec = 0;
  int n_bad = 0;
  logic [31:0] loc_a [4];
  logic        loc_v [4];

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // bench-side checksum arithmetic: integer accumulate, fold at the end
  function automatic int fold(input int s);
    int t = s;
    while (t > 32'hFFFF) t = (t & 32'hFFFF) + (t >>> 16);
    return t;
  endfunction

  function automatic int word_at(input logic [159:0] h, input int i);
    int hi = int'(h[159-16*i -: 8]);
    int lo = int'(h[151-16*i -: 8]);
    return hi * 256 + lo;
  endfunction

  function automatic logic [15:0] fresh_csum(input logic [159:0] h);
    int s = 0;
    for (int i = 0; i < 10; i++) if (i != 5) s += word_at(h, i);
    return ~16'(fold(s));
  endfunction

  function automatic bit sum_good(input logic [159:0] h);
    int s = 0;
    for (int i = 0; i < 10; i++) s += word_at(h, i);
    return fold(s) == 32'hFFFF;
  endfunction

  function automatic logic [159:0] mk_hdr(input logic [7:0] b0, input logic [7:0] ttl,
                                          input logic [31:0] dst);
    logic [159:0] h;
    h = {b0, 8'h00, 16'h0054, 16'h1c46, 16'h4000, ttl, 8'h11, 16'h0000,
         32'h0a000001, dst};
    h[79:64] = fresh_csum(h);
    return h;
  endfunction

  function automatic logic [2:0] ref_reason(input logic [15:0] et, input logic [159:0] h,
                                            input bit fc, input bit rh, input bit ah);
    bit local_hit = 1'b0;
    for (int e = 0; e < 4; e++) if (loc_v[e] && loc_a[e] == h[31:0]) local_hit = 1'b1;
    if (fc)                  return 3'd0; // R12
    if (et != 16'h0800)      return 3'd1; // R3
    if (h[159:152] != 8'h45) return 3'd2; // R4
    if (!sum_good(h))        return 3'd3; // R5
    if (local_hit)           return 3'd4; // R6
    if (h[95:88] <= 8'd1)    return 3'd5; // R7
    if (!rh)                 return 3'd6; // R8
    if (!ah)                 return 3'd7; // R8
    return 3'd0;
  endfunction

  task automatic apply(input logic [15:0] et, input logic [159:0] h, input bit fc,
                       input logic [1:0] ip, input bit rh, input logic [1:0] rp,
                       input bit ah, input string req);
    logic [2:0]  er;
    logic [7:0]  e_ttl, e_dp, e_cp;
    logic [15:0] e_cs;
    logic [159:0] h2;
    er = ref_reason(et, h, fc, rh, ah);
    if (fc) begin
      e_ttl = h[95:88]; e_cs = h[79:64];
      e_dp = 8'd1 << (2 * ip); e_cp = e_dp;
    end else if (er == 3'd0) begin
      h2 = h; h2[95:88] = h[95:88] - 8'd1;
      e_ttl = h2[95:88]; e_cs = fresh_csum(h2);
      e_dp = 8'd1 << (2 * rp); e_cp = e_dp;
    end else begin
      e_ttl = h[95:88]; e_cs = h[79:64];
      e_dp = 8'd0; e_cp = 8'd1 << (2 * ip + 1);
    end
    @(negedge clk);
    eth_type = et; ip_hdr = h; from_cpu = fc; in_port = ip;
    rt_hit = rh; rt_port = rp; arp_hit = ah; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check(d_valid == 1'b1, "R1", "out_valid", 32'(d_valid), 32'd1);
    check(d_rsn == er, req, "reason", 32'(d_rsn), 32'(er));
    check(d_ports == e_dp, (er == 0) ? "R2" : "R11", "ports", 32'(d_ports), 32'(e_dp));
    check(c_ports == e_cp, "R11", "cpu-variant ports", 32'(c_ports), 32'(e_cp));
    check(d_ttl == e_ttl, (er == 0 && !fc) ? "R10" : "R11", "ttl", 32'(d_ttl), 32'(e_ttl));
    check(d_csum == e_cs, (er == 0 && !fc) ? "R10" : "R11", "csum", 32'(d_csum), 32'(e_cs));
    @(negedge clk);
    check(d_valid == 1'b0, "R1", "out_valid drop", 32'(d_valid), 32'd0);
  endtask

  task automatic loc_write(input int idx, input logic [31:0] a, input bit v);
    @(negedge clk);
    loc_we = 1'b1; loc_idx = 2'(idx); loc_addr = a; loc_valid = v;
    @(negedge clk);
    loc_we = 1'b0;
    loc_a[idx] = a; loc_v[idx] = v;
  endtask

  initial begin
    #4_000_000;
    n_vec++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    logic [159:0] h;
    for (int e = 0; e < 4; e++) begin loc_a[e] = '0; loc_v[e] = 1'b0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state, R6 depth
    check(d_valid == 1'b0, "R1", "reset valid", 32'(d_valid), 32'd0);
    check(d_ports == 8'd0, "R1", "reset ports", 32'(d_ports), 32'd0);
    check(d_depth == 8'd4, "R6", "depth", 32'(d_depth), 32'd4);

    // R7/R10/R2: every TTL value, good header
    for (int t = 0; t < 256; t++)
      apply(16'h0800, mk_hdr(8'h45, 8'(t), 32'hc0a80a00 + 32'(t)), 1'b0,
            2'(t >> 2), 1'b1, 2'(t), 1'b1, "R7");

    // R4: every byte-0 value with valid checksum
    for (int b = 0; b < 256; b++)
      apply(16'h0800, mk_hdr(8'(b), 8'd64, 32'h08080808), 1'b0, 2'(b), 1'b1, 2'(b >> 2),
            1'b1, "R4");

    // R3: ethertypes including ARP
    apply(16'h0806, mk_hdr(8'h45, 8'd64, 32'h08080808), 1'b0, 2'd1, 1'b1, 2'd2, 1'b1, "R3");
    apply(16'h86dd, mk_hdr(8'h45, 8'd64, 32'h08080808), 1'b0, 2'd2, 1'b1, 2'd2, 1'b1, "R3");
    apply(16'h0801, mk_hdr(8'h45, 8'd64, 32'h08080808), 1'b0, 2'd3, 1'b1, 2'd2, 1'b1, "R3");

    // R5: single-bit flips across the whole header
    for (int k = 0; k < 160; k++) begin
      h = mk_hdr(8'h45, 8'd9, 32'h01020304);
      h[k] = ~h[k];
      apply(16'h0800, h, 1'b0, 2'(k), 1'b1, 2'(k >> 2), 1'b1, "R5");
    end

    // R8: route and ARP combinations
    for (int c = 0; c < 4; c++)
      apply(16'h0800, mk_hdr(8'h45, 8'd30, 32'h0b0b0b0b), 1'b0, 2'(c), c[0], 2'(3 - c),
            c[1], "R8");

    // R6: local table
    for (int e = 0; e < 4; e++) loc_write(e, 32'hc0a80001 + 32'(e), 1'b1);
    for (int e = 0; e < 4; e++)
      apply(16'h0800, mk_hdr(8'h45, 8'd64, 32'hc0a80001 + 32'(e)), 1'b0, 2'(e), 1'b1,
            2'd1, 1'b1, "R6");
    loc_write(2, 32'hc0a80003, 1'b0);
    apply(16'h0800, mk_hdr(8'h45, 8'd64, 32'hc0a80003), 1'b0, 2'd0, 1'b1, 2'd3, 1'b1, "R6");
    apply(16'h0800, mk_hdr(8'h45, 8'd64, 32'hc0a80005), 1'b0, 2'd0, 1'b1, 2'd2, 1'b1, "R6");

    // R9: stack all faults, clear one at a time
    h = mk_hdr(8'h46, 8'd1, 32'hc0a80001); h[79:64] = h[79:64] ^ 16'h0101;
    apply(16'h0806, h, 1'b0, 2'd1, 1'b0, 2'd0, 1'b0, "R9");
    apply(16'h0800, h, 1'b0, 2'd1, 1'b0, 2'd0, 1'b0, "R9");
    h = mk_hdr(8'h45, 8'd1, 32'hc0a80001); h[79:64] = h[79:64] ^ 16'h0101;
    apply(16'h0800, h, 1'b0, 2'd1, 1'b0, 2'd0, 1'b0, "R9");
    apply(16'h0800, mk_hdr(8'h45, 8'd1, 32'hc0a80001), 1'b0, 2'd1, 1'b0, 2'd0, 1'b0, "R9");
    apply(16'h0800, mk_hdr(8'h45, 8'd1, 32'h0a0a0a0a), 1'b0, 2'd1, 1'b0, 2'd0, 1'b0, "R9");
    apply(16'h0800, mk_hdr(8'h45, 8'd2, 32'h0a0a0a0a), 1'b0, 2'd1, 1'b0, 2'd0, 1'b0, "R9");
    apply(16'h0800, mk_hdr(8'h45, 8'd2, 32'h0a0a0a0a), 1'b0, 2'd1, 1'b1, 2'd0, 1'b0, "R9");
    apply(16'h0800, mk_hdr(8'h45, 8'd2, 32'h0a0a0a0a), 1'b0, 2'd1, 1'b1, 2'd0, 1'b1, "R9");

    // R12: software-injected frames, including broken ones
    for (int p = 0; p < 4; p++) begin
      h = mk_hdr(8'h45, 8'(p), 32'hc0a80001);
      h[70] = ~h[70];
      apply(16'h0806, h, 1'b1, 2'(p), 1'b0, 2'(3 - p), 1'b0, "R12");
      apply(16'h0800, mk_hdr(8'h45, 8'd77, 32'h0a000002), 1'b1, 2'(p), 1'b1, 2'(3 - p),
            1'b1, "R12");
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule